// File: doc/BRIEF.md
# Four-Stage Watchdog Timer

The block is a watchdog that counts on a prescaled timebase and steps through a fixed chain of timeout stages. Each stage has its own timeout. When a stage's time runs out, the block carries out that stage's configured action and moves on to the next stage. The possible actions are: do nothing, raise an interrupt, request a CPU reset, or request a system reset. After the last stage the chain wraps back to stage 0. Reset requests come out as pulses. The width of each pulse comes from a 3-bit code, and the code steps are not linear.

Software drives the block through a write-only register port. Enabling the watchdog, or writing the feed address while it runs, restarts the chain from stage 0 with fresh counters. A key register guards every other register. Once the key register holds anything other than its unlock value, all other writes are dropped. The current stage index is brought out so that the rest of the chip can see how far the chain has gone.

Top module: `staged_watchdog`

## Requirements
- R1: After reset the stage output is 0, all four event outputs are low, and the key register holds the unlock value, so that writes are accepted.
- R2: The timebase ticks once every P base clock cycles, where P is the prescale register (address 1, bits [15:0]). A prescale of 0 behaves as 1.
- R3: A stage with timeout T (addresses 2..5 for stages 0..3) expires after max(T,1) ticks. When a write enables the block, or a feed is accepted, at clock edge E, the first expiry happens at edge E + P*max(T,1).
- R4: Stages advance strictly in the order 0, 1, 2, 3, 0. A stage whose action is "none" still expires and advances.
- R5: The control register is at address 0. Its fields are: bit 0 enable, bit 1 level-interrupt enable, bit 2 edge-interrupt enable, bits [9:8],[11:10],[13:12],[15:14] actions of stages 0..3, bits [18:16] CPU pulse code, bits [22:20] system pulse code. Action codes are 0 none, 1 interrupt, 2 CPU reset, 3 system reset. The action's output is seen in the cycle that follows the expiry edge.
- R6: A reset pulse lasts exactly BASE_LEN*{1,2,3,4,5,8,16,32} cycles for codes 0..7. A new request reloads the length.
- R7: With edge-interrupt enable set, an interrupt stage gives a one-cycle pulse on irq_edge_o. With level-interrupt enable set, it sets irq_level_o, which stays high until a feed is accepted or the block is disabled.
- R8: A write of any data to address 6 while the block is enabled and unlocked restarts the chain at stage 0 and clears irq_level_o.
- R9: Address 7 is the key register and can always be written. While it holds a value other than UNLOCK_KEY, writes to addresses 0..6 have no effect.
- R10: While the block is disabled, the chain is held at stage 0 and irq_level_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| stage_o | output | SW | Index of the current stage |
| irq_level_o | output | 1 | Latched stage-timeout interrupt |
| irq_edge_o | output | 1 | One-cycle stage-timeout interrupt pulse |
| cpu_rst_o | output | 1 | CPU reset request pulse |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with four stages, 32-bit timeouts, a 16-bit prescaler and BASE_LEN of 2. With those values even the longest reset pulse (64 cycles) fits into a short run. Prescale values of 1 to 3 and timeouts of 1 to 4 mean that each random trial makes two full laps of the chain in about a hundred cycles. This covers the wrap from stage 3 back to 0, single-cycle stages, and back-to-back expiries. Directed cases exercise the zero prescale and zero timeout boundaries, all eight pulse codes, a feed in the middle of the chain, and writes made while the block is locked.

// File: rtl/wdt_stage_pkg.sv
package wdt_stage_pkg;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_IRQ  = 2'd1,
      ACT_CPU  = 2'd2,
      ACT_SYS  = 2'd3
   } wdt_act_e;

   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_PRESC = 3'd1;
   localparam logic [ADDR_W-1:0] A_TMO0  = 3'd2;
   localparam logic [ADDR_W-1:0] A_FEED  = 3'd6;
   localparam logic [ADDR_W-1:0] A_KEY   = 3'd7;

   localparam int F_EN      = 0;
   localparam int F_LVL     = 1;
   localparam int F_EDGE    = 2;
   localparam int F_ACT_LSB = 8;
   localparam int F_CPU_LSB = 16;
   localparam int F_SYS_LSB = 20;

   localparam int MAX_UNITS = 32;

   // pulse length in base units for a 3-bit code: linear up to 5, then doubling
   function automatic int unsigned len_units(input logic [2:0] code);
      int unsigned u;
      case (code)
         3'd5:    u = 8;
         3'd6:    u = 16;
         3'd7:    u = 32;
         default: u = int'(code) + 1;
      endcase
      return u;
   endfunction

endpackage

// File: rtl/wdt_presc.sv
module wdt_presc #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          restart,
   input  logic [PW-1:0] presc,
   output logic          tick
);

   logic [PW-1:0] pc_q;
   logic [PW-1:0] limit;

   assign limit = (presc == '0) ? '0 : presc - PW'(1);
   assign tick  = run && (pc_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (!run || restart || tick) begin
         pc_q <= '0;
      end else begin
         pc_q <= pc_q + PW'(1);
      end
   end

endmodule

// File: rtl/wdt_seq.sv
module wdt_seq #(
   parameter int NS = 4,
   parameter int TW = 32,
   localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic                   restart,
   input  logic                   tick,
   input  logic [NS-1:0][TW-1:0]  tmo,
   output logic [SW-1:0]          stage,
   output logic                   expire
);

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] tmo_cur;
   logic          last;
   logic [SW-1:0] stage_nxt;

   assign tmo_cur   = tmo[stage];
   assign last      = (tmo_cur <= TW'(1)) || (cnt_q >= tmo_cur - TW'(1));
   assign expire    = run && !restart && tick && last;
   assign stage_nxt = (stage == SW'(NS - 1)) ? '0 : stage + SW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         stage <= '0;
      end else if (!run || restart) begin
         cnt_q <= '0;
         stage <= '0;
      end else if (expire) begin
         cnt_q <= '0;
         stage <= stage_nxt;
      end else if (tick) begin
         cnt_q <= cnt_q + TW'(1);
      end
   end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse import wdt_stage_pkg::*; #(
   parameter int BASE_LEN = 8,
   localparam int MAXL = MAX_UNITS * BASE_LEN,
   localparam int CW = $clog2(MAXL + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fire,
   input  logic [2:0] code,
   output logic       pulse
);

   logic [CW-1:0] rem_q;
   logic [CW-1:0] load;

   assign load  = CW'(BASE_LEN * len_units(code));
   assign pulse = (rem_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (fire) begin
         rem_q <= load;
      end else if (rem_q != '0) begin
         rem_q <= rem_q - CW'(1);
      end
   end

endmodule

// File: rtl/staged_watchdog.sv
module staged_watchdog import wdt_stage_pkg::*; #(
   parameter int NUM_STAGES = 4,
   parameter int TMO_W      = 32,
   parameter int PRESC_W    = 16,
   parameter int DATA_W     = 32,
   parameter int BASE_LEN   = 8,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = DATA_W'(32'hA5C3_0F69),
   localparam int SW = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SW-1:0]     stage_o,
   output logic              irq_level_o,
   output logic              irq_edge_o,
   output logic              cpu_rst_o,
   output logic              sys_rst_o
);

   localparam int NPULSE = 2;

   if (NUM_STAGES < 2 || NUM_STAGES > 4) begin : g_bad_ns
      $error("NUM_STAGES must be 2..4 to fit the action field");
   end
   if (DATA_W < 23 || DATA_W < TMO_W || DATA_W < PRESC_W) begin : g_bad_dw
      $error("DATA_W too narrow for the register fields");
   end
   if (BASE_LEN < 1) begin : g_bad_len
      $error("BASE_LEN must be at least 1");
   end

   // configuration state
   logic                               en_q, lvl_en_q, edge_en_q;
   logic [NUM_STAGES-1:0][1:0]         act_q;
   logic [2:0]                         cpu_len_q, sys_len_q;
   logic [PRESC_W-1:0]                 presc_q;
   logic [NUM_STAGES-1:0][TMO_W-1:0]   tmo_q;
   logic [DATA_W-1:0]                  key_q;

   logic unlocked, wr_ok, feed_acc;
   logic tick, expire;
   logic [SW-1:0] stage;
   logic [1:0] act_cur;

   assign unlocked = (key_q == UNLOCK_KEY);
   assign wr_ok    = wr_en && (unlocked || wr_addr == A_KEY);
   assign feed_acc = wr_ok && (wr_addr == A_FEED) && en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         lvl_en_q  <= 1'b0;
         edge_en_q <= 1'b0;
         act_q     <= '0;
         cpu_len_q <= '0;
         sys_len_q <= '0;
      end else if (wr_ok && wr_addr == A_CTRL) begin
         en_q      <= wr_data[F_EN];
         lvl_en_q  <= wr_data[F_LVL];
         edge_en_q <= wr_data[F_EDGE];
         for (int s = 0; s < NUM_STAGES; s++) begin
            act_q[s] <= wr_data[F_ACT_LSB + 2*s +: 2];
         end
         cpu_len_q <= wr_data[F_CPU_LSB +: 3];
         sys_len_q <= wr_data[F_SYS_LSB +: 3];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q <= PRESC_W'(1);
      end else if (wr_ok && wr_addr == A_PRESC) begin
         presc_q <= wr_data[PRESC_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_q <= '1;
      end else begin
         for (int s = 0; s < NUM_STAGES; s++) begin
            if (wr_ok && wr_addr == ADDR_W'(int'(A_TMO0) + s)) begin
               tmo_q[s] <= wr_data[TMO_W-1:0];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= UNLOCK_KEY;
      end else if (wr_en && wr_addr == A_KEY) begin
         key_q <= wr_data;
      end
   end

   // timebase and stage chain
   wdt_presc #(.PW(PRESC_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q),
      .restart (feed_acc),
      .presc   (presc_q),
      .tick    (tick)
   );

   wdt_seq #(.NS(NUM_STAGES), .TW(TMO_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q),
      .restart (feed_acc),
      .tick    (tick),
      .tmo     (tmo_q),
      .stage   (stage),
      .expire  (expire)
   );

   assign act_cur = act_q[stage];
   assign stage_o = stage;

   // interrupt outputs
   logic irq_edge_q, irq_lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_edge_q <= 1'b0;
         irq_lvl_q  <= 1'b0;
      end else begin
         irq_edge_q <= expire && (act_cur == ACT_IRQ) && edge_en_q;
         if (!en_q || feed_acc) begin
            irq_lvl_q <= 1'b0;
         end else if (expire && (act_cur == ACT_IRQ) && lvl_en_q) begin
            irq_lvl_q <= 1'b1;
         end
      end
   end

   assign irq_edge_o  = irq_edge_q;
   assign irq_level_o = irq_lvl_q;

   // reset pulse generators: index 0 CPU, index 1 system
   logic [NPULSE-1:0]      fire;
   logic [NPULSE-1:0][2:0] code;
   logic [NPULSE-1:0]      pulse;

   assign fire[0] = expire && (act_cur == ACT_CPU);
   assign fire[1] = expire && (act_cur == ACT_SYS);
   assign code[0] = cpu_len_q;
   assign code[1] = sys_len_q;

   for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
      wdt_pulse #(.BASE_LEN(BASE_LEN)) u_pulse (
         .clk   (clk),
         .rst_n (rst_n),
         .fire  (fire[g]),
         .code  (code[g]),
         .pulse (pulse[g])
      );
   end

   assign cpu_rst_o = pulse[0];
   assign sys_rst_o = pulse[1];

endmodule

// File: rtl/wdt_stage_chk.sv
module wdt_stage_chk import wdt_stage_pkg::*; #(
   parameter int SW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [2:0]    wr_addr,
   input logic [SW-1:0] stage,
   input logic          run,
   input logic          unlocked,
   input logic          expire,
   input logic [1:0]    act_cur,
   input logic          irq_level,
   input logic          irq_edge,
   input logic          sys_rst
);

   AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (stage != $past(stage)) |-> (stage == '0 || int'(stage) == int'($past(stage)) + 1)); // R4

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (stage == '0 && !irq_level)); // R10

   AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !unlocked && wr_addr == A_CTRL) |=> $stable(run)); // R9

   AST_FEED_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && unlocked && wr_addr == A_FEED && run) |=> (stage == '0)); // R8

   AST_SYS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> $past(expire && act_cur == ACT_SYS)); // R5

   AST_EDGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_edge |-> $past(expire && act_cur == ACT_IRQ)); // R7

endmodule

bind staged_watchdog wdt_stage_chk #(.SW(SW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .stage     (stage),
   .run       (en_q),
   .unlocked  (unlocked),
   .expire    (expire),
   .act_cur   (act_cur),
   .irq_level (irq_level_o),
   .irq_edge  (irq_edge_o),
   .sys_rst   (sys_rst_o)
);

// File: tb/staged_watchdog_tb.sv
`timescale 1ns/1ps
module staged_watchdog_tb_top;

   localparam int BASE = 2;
   localparam logic [31:0] KEY = 32'hA5C3_0F69;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  stage_o;
   logic        irq_level_o, irq_edge_o, cpu_rst_o, sys_rst_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   staged_watchdog #(
      .NUM_STAGES(4), .TMO_W(32), .PRESC_W(16), .DATA_W(32),
      .BASE_LEN(BASE), .UNLOCK_KEY(KEY)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .stage_o(stage_o), .irq_level_o(irq_level_o), .irq_edge_o(irq_edge_o),
      .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // called at a negedge: write lands on the next posedge, returns at the following negedge
   task automatic wr(input int addr, input logic [31:0] data);
      wr_en   = 1'b1;
      wr_addr = 3'(addr);
      wr_data = data;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [31:0] mk_ctrl(input bit en, input bit lv, input bit ed,
                                           input logic [7:0] acts,
                                           input logic [2:0] cl, input logic [2:0] sl);
      return {9'd0, sl, 1'b0, cl, acts, 5'd0, ed, lv, en};
   endfunction

   function automatic int exp_len(input int code);
      case (code)
         5: return BASE * 8;
         6: return BASE * 16;
         7: return BASE * 32;
         default: return BASE * (code + 1);
      endcase
   endfunction

   // run a single system or CPU pulse from stage 0 and measure its width
   task automatic pulse_test(input bit sys, input int code);
      int L;
      L = exp_len(code);
      wr(2, 1); wr(3, 1000); wr(4, 1000); wr(5, 1000); wr(1, 1);
      wr(0, mk_ctrl(1, 0, 0, sys ? 8'h03 : 8'h02, 3'(code), 3'(code)));
      @(negedge clk);
      chk("R6 pulse start", sys ? sys_rst_o : cpu_rst_o, 1);
      wait_n(L - 1);
      chk("R6 pulse last cycle", sys ? sys_rst_o : cpu_rst_o, 1);
      @(negedge clk);
      chk("R6 pulse end", sys ? sys_rst_o : cpu_rst_o, 0);
      wr(0, 0);
      wait_n(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int p;
      int tm[4];
      logic [7:0] acts;
      bit lv, ed, seen;
      int s, a;

      void'($urandom(32'd20240611));
      wait_n(4);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 stage", stage_o, 0);
      chk("R1 level irq", irq_level_o, 0);
      chk("R1 edge irq", irq_edge_o, 0);
      chk("R1 cpu rst", cpu_rst_o, 0);
      chk("R1 sys rst", sys_rst_o, 0);

      // R2/R3 zero prescale and zero timeout behave as 1
      wr(2, 0); wr(3, 3); wr(4, 50); wr(5, 50); wr(1, 0);
      wr(0, mk_ctrl(1, 0, 0, 8'h00, 0, 0));
      @(negedge clk);
      chk("R3 zero timeout", stage_o, 1);
      wait_n(2);
      chk("R2 zero prescale", stage_o, 1);
      @(negedge clk);
      chk("R2 zero prescale", stage_o, 2);
      wr(0, 0);
      @(negedge clk);
      chk("R10 disabled", stage_o, 0);

      // R6 all pulse codes
      for (int c = 0; c < 8; c++) pulse_test(1'b1, c);
      pulse_test(1'b0, 0);
      pulse_test(1'b0, 5);
      pulse_test(1'b0, 7);

      // R8 feed mid-chain clears the level interrupt
      wr(2, 2); wr(3, 20); wr(4, 20); wr(5, 20); wr(1, 1);
      wr(0, mk_ctrl(1, 1, 0, 8'h01, 0, 0));   // E
      wait_n(2);                               // E+2.5
      chk("R3 stage0 expiry", stage_o, 1);
      chk("R7 level set", irq_level_o, 1);
      wait_n(2);
      wr(6, 32'hDEAD_0000);                    // feed at F
      chk("R8 feed restart", stage_o, 0);
      chk("R8 feed clears level", irq_level_o, 0);
      @(negedge clk);
      chk("R8 stage0 again", stage_o, 0);
      @(negedge clk);                          // F+2.5
      chk("R8 expiry after feed", stage_o, 1);

      // R9 locked: feed and control writes ignored
      wr(7, 32'h0);                            // lock
      wr(6, 32'h1);                            // ignored feed
      chk("R9 feed ignored", stage_o, 1);
      wait_n(17);                              // F+21.5
      chk("R9 stage1 still running", stage_o, 1);
      @(negedge clk);
      chk("R9 chain kept going", stage_o, 2);
      wr(0, 0);                                // ignored disable
      wait_n(2);
      chk("R9 control write ignored", stage_o, 2);
      wr(7, KEY);
      wr(0, 0);
      @(negedge clk);
      chk("R9 unlocked write works", stage_o, 0);

      // R9 enable write while locked has no effect
      wr(2, 1); wr(1, 1);
      wr(7, 32'h1234);
      wr(0, mk_ctrl(1, 0, 0, 8'h00, 0, 0));
      wait_n(4);
      chk("R9 enable ignored", stage_o, 0);
      wr(7, KEY);

      // random configurations, two laps each
      for (int t = 0; t < 30; t++) begin
         p = 1 + int'($urandom % 3);
         lv = 1'($urandom % 2);
         ed = 1'($urandom % 2);
         seen = 1'b0;
         for (int k = 0; k < 4; k++) begin
            tm[k] = 1 + int'($urandom % 4);
            acts[2*k +: 2] = 2'($urandom % 4);
            wr(2 + k, tm[k]);
         end
         wr(1, p);
         wr(0, mk_ctrl(1, lv, ed, acts, 3'($urandom % 8), 3'($urandom % 8)));
         for (int k = 0; k < 8; k++) begin
            s = k % 4;
            a = int'(acts[2*s +: 2]);
            wait_n(p * tm[s] - 1);
            chk("R3 stage held until expiry", stage_o, s);
            @(negedge clk);
            chk("R4 next stage", stage_o, (s + 1) % 4);
            if (a == 1 && lv) seen = 1'b1;
            chk("R7 level irq", irq_level_o, seen);
            chk("R7 edge irq", irq_edge_o, (a == 1 && ed) ? 1 : 0);
            if (a == 2) chk("R5 cpu reset action", cpu_rst_o, 1);
            if (a == 3) chk("R5 system reset action", sys_rst_o, 1);
         end
         wr(0, 0);
         @(negedge clk);
         chk("R10 off clears level", irq_level_o, 0);
         wait_n(70);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule